// File: doc/BRIEF.md
# UART FIFO Trigger-Level Interrupt Controller

This block holds the transmit and receive byte queues of one UART channel and raises the data interrupts that tell the CPU when to service them. The CPU reloads the transmit queue and drains the receive queue. The serial shifters take bytes from the transmit queue and deposit bytes into the receive queue. Three small registers are written from the CPU side: a FIFO control byte, an enhanced-feature byte and a trigger-table byte.

The interrupt thresholds come from one of two level tables. A single table selection governs both directions. The receive interrupt follows the fill level. The transmit interrupt uses hysteresis: it fires at the threshold only if the previous reload pushed the queue above the threshold. Otherwise it waits until the queue runs dry. Each queue can be flushed through a self-clearing bit of the control byte, and that flush leaves the other queue untouched.

Top module: `fifo_trig_ctrl`

## Requirements
- R1: After reset both counts are 0, all three registers read 0x00, and both interrupts are low.
- R2: Each queue returns bytes in the order they entered, and its count tracks accepted pushes and pops, up to 64 entries.
- R3: A push into a full queue is dropped and the count stays at 64. A pop from an empty queue is dropped and the count stays at 0.
- R4: Control bit 1 flushes the receive queue and bit 2 flushes the transmit queue. A flush happens only if bit 0 is 1 in the same write. The other queue is kept. Bits 1 and 2 always read back as 0.
- R5: The control register at address 0 reads as {rxCode[7:6], txCode[5:4], dmaMode[3], 0, 0, fifoEnable[0]}. The bits dmaMode and fifoEnable store the written value.
- R6: txCode (control bits 5:4) is updated only while bit 4 of the enhanced register (address 1) is 1. Otherwise it keeps its value.
- R7: Bits 5:4 of the table register (address 2) select the level table. Code 01 selects table B, and any other code selects table A. The same table applies to both directions.
- R8: The receive level for rxCode 00/01/10/11 is 1/4/8/14 in table A and 8/16/24/28 in table B.
- R9: The transmit level is 1 for any txCode in table A. In table B it is 16/8/24/30 for txCode 00/01/10/11.
- R10: rxIrq is high exactly when the receive count is at or above the receive level.
- R11: txIrq rises on a pop that empties the queue. It also rises on a pop that leaves the count below the level, provided the last reload brought the count above the level.
- R12: Any CPU write strobe to the transmit queue clears txIrq on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address (0 control, 1 enhanced, 2 table) |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Contents of the addressed register |
| txWr | input | 1 | CPU write into the transmit queue |
| txWrData | input | DATA_W (8) | Byte written by the CPU |
| txPop | input | 1 | Shifter takes the head byte of the transmit queue |
| txPopData | output | DATA_W (8) | Head of the transmit queue |
| txCount | output | 7 | Transmit queue fill level |
| rxPush | input | 1 | Shifter deposits a received byte |
| rxPushData | input | DATA_W (8) | Received byte |
| rxRd | input | 1 | CPU reads the head byte of the receive queue |
| rxRdData | output | DATA_W (8) | Head of the receive queue |
| rxCount | output | 7 | Receive queue fill level |
| txIrq | output | 1 | Transmit data interrupt |
| rxIrq | output | 1 | Receive data interrupt |

## Verification
The bench sweeps all four table-select codes against all four level codes in both directions. A wrong table entry, or a design that does not fall back to table A for the unused codes, shows up as an interrupt that appears one byte early or late.

The transmit hysteresis is tested with a reload that stays below the threshold. A design that ignores the rule raises txIrq at the threshold instead of waiting for empty.

Flush writes with bit 0 clear must do nothing, and a flush of one queue must spare the other. A design that decodes the reset bits alone loses data.

Overfilling and overdraining the queues catches pointer wrap and count saturation errors through the scoreboard.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txClear;
    logic rxPush;
    logic rxPop;
    logic rxClear;
  } fifoStrobes_t;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_ENH   = 2'd1;
  localparam logic [1:0] ADDR_TABLE = 2'd2;

  localparam logic [1:0] TABLE_B_CODE = 2'b01;

endpackage

// File: rtl/ftc_fifo.sv
module ftc_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic              clear,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdData = mem[rdPtr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |-> (count != CNT_W'(DEPTH))) else $error("push into full queue"); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0)) else $error("pop from empty queue"); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (count == '0)) else $error("flush left entries"); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)) else $error("count beyond depth"); // R2

endmodule

// File: rtl/ftc_datapath.sv
module ftc_datapath
  import ftc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] txWrData,
  input  logic [DATA_W-1:0] rxPushData,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);

  ftc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uTxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobes.txPush),
    .pop    (strobes.txPop),
    .clear  (strobes.txClear),
    .wrData (txWrData),
    .rdData (txHead),
    .count  (txCount)
  );

  ftc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uRxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobes.rxPush),
    .pop    (strobes.rxPop),
    .clear  (strobes.rxClear),
    .wrData (rxPushData),
    .rdData (rxHead),
    .count  (rxCount)
  );

endmodule

// File: rtl/ftc_control.sv
module ftc_control
  import ftc_pkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             txWr,
  input  logic             txPopReq,
  input  logic             rxPushReq,
  input  logic             rxRdReq,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  output fifoStrobes_t     strobes,
  output logic             txIrq,
  output logic             rxIrq
);

  logic       fifoEnable, dmaMode, enhEnable;
  logic [1:0] txCode, rxCode, tableSel;
  logic       ctrlWr, useTableB;
  logic [CNT_W-1:0] txLevel, rxLevel, txNext;
  logic       txFull, txEmpty, rxFull, rxEmpty;
  logic       filledAbove;

  assign ctrlWr  = regWr && (regAddr == ADDR_CTRL);
  assign txFull  = (txCount == CNT_W'(DEPTH));
  assign rxFull  = (rxCount == CNT_W'(DEPTH));
  assign txEmpty = (txCount == '0);
  assign rxEmpty = (rxCount == '0);

  // strobes to the datapath; a flush overrides traffic in the same cycle
  always_comb begin
    strobes.txClear = ctrlWr && regWrData[0] && regWrData[2];
    strobes.rxClear = ctrlWr && regWrData[0] && regWrData[1];
    strobes.txPush  = txWr && !txFull && !strobes.txClear;
    strobes.txPop   = txPopReq && !txEmpty && !strobes.txClear;
    strobes.rxPush  = rxPushReq && !rxFull && !strobes.rxClear;
    strobes.rxPop   = rxRdReq && !rxEmpty && !strobes.rxClear;
  end

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnable <= 1'b0;
      dmaMode    <= 1'b0;
      txCode     <= 2'b00;
      rxCode     <= 2'b00;
      enhEnable  <= 1'b0;
      tableSel   <= 2'b00;
    end else if (regWr) begin
      case (regAddr)
        ADDR_CTRL: begin
          fifoEnable <= regWrData[0];
          dmaMode    <= regWrData[3];
          rxCode     <= regWrData[7:6];
          if (enhEnable) txCode <= regWrData[5:4];
        end
        ADDR_ENH:   enhEnable <= regWrData[4];
        ADDR_TABLE: tableSel  <= regWrData[5:4];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  regRdData = {rxCode, txCode, dmaMode, 2'b00, fifoEnable};
      ADDR_ENH:   regRdData = {3'b000, enhEnable, 4'b0000};
      ADDR_TABLE: regRdData = {2'b00, tableSel, 4'b0000};
      default:    regRdData = 8'h00;
    endcase
  end

  // trigger table decode
  assign useTableB = (tableSel == TABLE_B_CODE);

  always_comb begin
    if (useTableB) begin
      case (rxCode)
        2'd0: rxLevel = CNT_W'(8);
        2'd1: rxLevel = CNT_W'(16);
        2'd2: rxLevel = CNT_W'(24);
        default: rxLevel = CNT_W'(28);
      endcase
      case (txCode)
        2'd0: txLevel = CNT_W'(16);
        2'd1: txLevel = CNT_W'(8);
        2'd2: txLevel = CNT_W'(24);
        default: txLevel = CNT_W'(30);
      endcase
    end else begin
      case (rxCode)
        2'd0: rxLevel = CNT_W'(1);
        2'd1: rxLevel = CNT_W'(4);
        2'd2: rxLevel = CNT_W'(8);
        default: rxLevel = CNT_W'(14);
      endcase
      txLevel = CNT_W'(1);
    end
  end

  assign rxIrq = (rxCount >= rxLevel);

  // transmit interrupt with reload hysteresis
  always_comb begin
    txNext = txCount;
    if (strobes.txPush && !strobes.txPop) txNext = txCount + 1'b1;
    if (strobes.txPop && !strobes.txPush) txNext = txCount - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrq       <= 1'b0;
      filledAbove <= 1'b0;
    end else if (strobes.txClear) begin
      txIrq       <= 1'b0;
      filledAbove <= 1'b0;
    end else if (txWr) begin
      txIrq <= 1'b0;
      if (strobes.txPush && (txNext > txLevel)) filledAbove <= 1'b1;
    end else if (strobes.txPop) begin
      if ((txNext == '0) || (filledAbove && (txNext < txLevel))) begin
        txIrq       <= 1'b1;
        filledAbove <= 1'b0;
      end
    end
  end

  AST_TX_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    txWr |=> !txIrq) else $error("txIrq survived a CPU write"); // R12
  AST_TX_IRQ_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txIrq) |-> (txCount < txLevel)) else $error("txIrq rose at or above level"); // R11
  AST_TXCODE_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !enhEnable) |=> (txCode == $past(txCode))) else $error("txCode changed while locked"); // R6
  AST_DMA_STORE: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> (dmaMode == $past(regWrData[3]))) else $error("dma bit not stored"); // R5

endmodule

// File: rtl/fifo_trig_ctrl.sv
module fifo_trig_ctrl
  import ftc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              txWr,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              txPop,
  output logic [DATA_W-1:0] txPopData,
  output logic [CNT_W-1:0]  txCount,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxRd,
  output logic [DATA_W-1:0] rxRdData,
  output logic [CNT_W-1:0]  rxCount,
  output logic              txIrq,
  output logic              rxIrq
);

  fifoStrobes_t strobes;

  ftc_control #(.DEPTH(DEPTH)) uControl (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .txWr      (txWr),
    .txPopReq  (txPop),
    .rxPushReq (rxPush),
    .rxRdReq   (rxRd),
    .txCount   (txCount),
    .rxCount   (rxCount),
    .strobes   (strobes),
    .txIrq     (txIrq),
    .rxIrq     (rxIrq)
  );

  ftc_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uDatapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .txWrData   (txWrData),
    .rxPushData (rxPushData),
    .txHead     (txPopData),
    .rxHead     (rxRdData),
    .txCount    (txCount),
    .rxCount    (rxCount)
  );

endmodule

// File: tb/sim_fifo_trig_ctrl.sv
module sim_fifo_trig_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       txWr = 1'b0;
  logic [7:0] txWrData = 8'h00;
  logic       txPop = 1'b0;
  logic [7:0] txPopData;
  logic [6:0] txCount;
  logic       rxPush = 1'b0;
  logic [7:0] rxPushData = 8'h00;
  logic       rxRd = 1'b0;
  logic [7:0] rxRdData;
  logic [6:0] rxCount;
  logic       txIrq, rxIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];

  always #4 clk = ~clk;  // 125 MHz

  fifo_trig_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .txWr(txWr), .txWrData(txWrData), .txPop(txPop), .txPopData(txPopData),
    .txCount(txCount), .rxPush(rxPush), .rxPushData(rxPushData), .rxRd(rxRd),
    .rxRdData(rxRdData), .rxCount(rxCount), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  task automatic check(input string req, input int actual, input int expected);
    nChecks++;
    if (actual !== expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  // driver side: expected bytes enter the scoreboard queues
  task automatic pushTx(input logic [7:0] b);
    if (txCount < 7'd64) txQ.push_back(b);
    txWr = 1'b1; txWrData = b;
    tick();
    txWr = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] b);
    if (rxCount < 7'd64) rxQ.push_back(b);
    rxPush = 1'b1; rxPushData = b;
    tick();
    rxPush = 1'b0;
  endtask

  // monitor side: head bytes are compared against the scoreboard
  task automatic popTx(input string req);
    if (txQ.size() > 0) check(req, txPopData, txQ.pop_front());
    txPop = 1'b1;
    tick();
    txPop = 1'b0;
  endtask

  task automatic popRx(input string req);
    if (rxQ.size() > 0) check(req, rxRdData, rxQ.pop_front());
    rxRd = 1'b1;
    tick();
    rxRd = 1'b0;
  endtask

  function automatic int expRx(input int tbl, input int code);
    if (tbl == 1) return (code == 0) ? 8 : (code == 1) ? 16 : (code == 2) ? 24 : 28;
    return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
  endfunction

  function automatic int expTx(input int tbl, input int code);
    if (tbl == 1) return (code == 0) ? 16 : (code == 1) ? 8 : (code == 2) ? 24 : 30;
    return 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    tick();

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      regRead(2'(a), v);
      check("R1 register", v, 0);
    end
    check("R1 txCount", txCount, 0);
    check("R1 rxCount", rxCount, 0);
    check("R1 txIrq", txIrq, 0);
    check("R1 rxIrq", rxIrq, 0);

    // R5 / R6 register behaviour
    regWrite(2'd1, 8'h10);
    regWrite(2'd2, 8'h10);
    regWrite(2'd0, 8'hB9);
    regRead(2'd0, v);
    check("R5 ctrl readback", v, 8'hB9);
    regRead(2'd1, v);
    check("R6 enhanced readback", v, 8'h10);
    regWrite(2'd1, 8'h00);
    regWrite(2'd0, 8'h09);
    regRead(2'd0, v);
    check("R6 txCode kept while locked", v, 8'h39);
    regWrite(2'd1, 8'h10);
    regWrite(2'd0, 8'h01);
    regRead(2'd0, v);
    check("R6 txCode written while enabled", v, 8'h01);

    // R4 flush gating
    for (int i = 0; i < 3; i++) pushTx(8'(8'h30 + i));
    for (int i = 0; i < 2; i++) pushRx(8'(8'h50 + i));
    regWrite(2'd0, 8'h06);
    check("R4 no flush without enable tx", txCount, 3);
    check("R4 no flush without enable rx", rxCount, 2);
    regWrite(2'd0, 8'h05);
    check("R4 tx flushed", txCount, 0);
    check("R4 rx spared", rxCount, 2);
    txQ.delete();
    regRead(2'd0, v);
    check("R4 reset bits read zero", v, 8'h01);
    regWrite(2'd0, 8'h03);
    check("R4 rx flushed", rxCount, 0);
    check("R4 tx stays empty", txCount, 0);
    rxQ.delete();

    // R2 / R3 transmit queue capacity and order
    for (int i = 0; i < 64; i++) pushTx(8'(i * 7 + 3));
    check("R2 tx count full", txCount, 64);
    pushTx(8'hEE);
    check("R3 tx push at full dropped", txCount, 64);
    for (int i = 0; i < 64; i++) popTx("R2 tx order");
    check("R2 tx drained", txCount, 0);
    popTx("R3 tx pop at empty");
    check("R3 tx pop at empty dropped", txCount, 0);

    // R2 / R3 receive queue
    for (int i = 0; i < 65; i++) pushRx(8'(255 - i * 3));
    check("R3 rx push at full dropped", rxCount, 64);
    for (int i = 0; i < 64; i++) popRx("R2 rx order");
    popRx("R3 rx pop at empty");
    check("R3 rx pop at empty dropped", rxCount, 0);

    // R7 / R8 / R10 receive levels over all table codes
    for (int tbl = 0; tbl < 4; tbl++) begin
      for (int code = 0; code < 4; code++) begin
        int lvl;
        regWrite(2'd2, 8'(tbl << 4));
        regWrite(2'd0, 8'(8'h03 | (code << 6)));
        rxQ.delete();
        lvl = expRx(tbl, code);
        for (int i = 0; i < lvl - 1; i++) pushRx(8'(i + tbl * 16 + code));
        check($sformatf("R8 R10 rxIrq below level t%0d c%0d", tbl, code), rxIrq, 0);
        pushRx(8'hA5);
        check($sformatf("R7 R10 rxIrq at level t%0d c%0d", tbl, code), rxIrq, 1);
        popRx("R10 rx data");
        check($sformatf("R10 rxIrq drops t%0d c%0d", tbl, code), rxIrq, 0);
      end
    end
    regWrite(2'd0, 8'h03);
    rxQ.delete();

    // R7 / R9 / R11 transmit levels over all table codes
    regWrite(2'd1, 8'h10);
    for (int tbl = 0; tbl < 4; tbl++) begin
      for (int code = 0; code < 4; code++) begin
        int lvl;
        regWrite(2'd2, 8'(tbl << 4));
        regWrite(2'd0, 8'(8'h05 | (code << 4)));
        txQ.delete();
        lvl = expTx(tbl, code);
        for (int i = 0; i <= lvl; i++) pushTx(8'(i ^ 8'h5A));
        check("R12 txIrq low after reload", txIrq, 0);
        popTx("R9 tx data");
        check($sformatf("R9 txIrq at level t%0d c%0d", tbl, code), txIrq, 0);
        popTx("R9 tx data");
        check($sformatf("R9 R11 txIrq below level t%0d c%0d", tbl, code), txIrq, 1);
        while (txCount != 0) popTx("R9 tx data");
      end
    end

    // R11 hysteresis: reload stays under the level, so only empty fires
    regWrite(2'd2, 8'h10);
    regWrite(2'd0, 8'h05);
    txQ.delete();
    for (int i = 0; i < 10; i++) pushTx(8'(i + 100));
    for (int i = 0; i < 9; i++) popTx("R11 tx data");
    check("R11 no txIrq below level after short reload", txIrq, 0);
    popTx("R11 tx data");
    check("R11 txIrq on empty", txIrq, 1);
    pushTx(8'h77);
    check("R12 txIrq cleared by write", txIrq, 0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule